// File: doc/BRIEF.md
# DRAM Refresh Controller

This block produces refresh cycles for an asynchronous DRAM. Two methods are supported. The first is CAS-before-RAS refresh, which issues one refresh burst for each underflow pulse from an external 8-bit interval timer. The second is self-refresh, in which the block holds RAS and CAS low for as long as software keeps the mode selected. The block shares the RAS and CAS strobes with the normal access sequencer. Before it touches the strobes, it raises a request and waits for a grant. The grant tells the sequencer to leave successive-RAS operation and close its open row. The sequencer then precharges before its next normal cycle.

Software configures the block through five inputs: an enable bit, a method bit, a precharge-to-CAS delay bit, a two-bit RAS width code and a two-bit precharge code. A CAS-before-RAS burst runs in this order: delay, CAS alone, RAS and CAS together, precharge. An underflow that arrives while the bus is busy is remembered as one pending request.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: While and after a synchronous reset, `ras_n_o` and `cas_n_o` are 1 and `req_o` and `own_o` are 0, and no refresh is pending.
- R2: With `rfsh_en_i`=1 and `self_mode_i`=0, a one-cycle `tick_i` raises `req_o` in the next cycle. With `rfsh_en_i`=0, ticks are ignored: `req_o` and `own_o` stay 0.
- R3: After a grant, both strobes stay high for D cycles, where D is 1 when `dly_sel_i`=0 and 2 when it is 1. `cas_n_o` then goes low alone for exactly one cycle.
- R4: In a CAS-before-RAS burst, `ras_n_o` stays low for 2 + `ras_w_i` cycles (codes 00..11 give 2..5). `cas_n_o` is low during that whole window and rises in the same cycle as `ras_n_o`. `ras_n_o` is never low while `cas_n_o` is high.
- R5: After a refresh, both strobes stay high with `own_o`=1 for 1 + `pre_cnt_i` cycles (codes 00..11 give 1..4). `own_o` then falls.
- R6: Any number of ticks that arrive while a refresh is running, or while the grant is withheld, produce exactly one further refresh.
- R7: With `rfsh_en_i`=1 and `self_mode_i`=1, the block requests the bus. After the grant it runs the R3 delay and the single CAS cycle. It then keeps both strobes low for as long as both bits stay 1.
- R8: When either bit is cleared during self-refresh, both strobes rise in the next cycle. They stay high with `own_o`=1 for the R5 precharge count before `own_o` falls.
- R9: `req_o` stays 1 while `gnt_i`=0 and `own_o` stays 0. `own_o` rises only in the cycle after `req_o` and `gnt_i` were both 1.
- R10: Ticks that arrive while `self_mode_i`=1 leave no pending refresh behind: no CAS-before-RAS burst follows the exit from self-refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rfsh_en_i | input | 1 | Refresh enable |
| self_mode_i | input | 1 | Method: 1 self-refresh, 0 CAS-before-RAS |
| dly_sel_i | input | 1 | Precharge-to-CAS delay: 0 one cycle, 1 two cycles |
| ras_w_i | input | 2 | RAS low width code, width = 2 + code |
| pre_cnt_i | input | 2 | Precharge count code, cycles = 1 + code |
| tick_i | input | 1 | Underflow pulse from the interval timer |
| gnt_i | input | 1 | Bus grant from the access sequencer |
| req_o | output | 1 | Refresh bus request to the access sequencer |
| own_o | output | 1 | Refresh controller drives the strobes |
| ras_n_o | output | 1 | Active-low RAS strobe |
| cas_n_o | output | 1 | Active-low CAS strobe |

## Verification
A wrong phase counter or a bad state transition shows up in the strobe pattern within one burst. The delay, CAS, RAS or precharge windows come out one or more cycles too long or too short. A corrupted pending flag shows up within one refresh period as a missing or an extra `own_o` rise. A latched request that was not cleared shows up as a spurious burst right after self-refresh ends. The bench therefore sweeps every delay, width and precharge code and compares the strobes cycle by cycle against arithmetic expectations.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    localparam int CNT_W   = 3;
    localparam int RAS_MIN = 2;
    localparam int PRE_MIN = 1;
    localparam int DLY_MIN = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DLY,
        ST_CAS,
        ST_RAS,
        ST_SELF,
        ST_PRE
    } rfsh_state_e;

    typedef struct packed {
        logic       dly_sel;
        logic [1:0] ras_w;
        logic [1:0] pre_n;
    } rfsh_cfg_t;

    // Counter reload values are the phase length minus one.
    function automatic logic [CNT_W-1:0] dly_load(input logic sel);
        return CNT_W'(DLY_MIN - 1 + int'(sel));
    endfunction

    function automatic logic [CNT_W-1:0] ras_load(input logic [1:0] code);
        return CNT_W'(RAS_MIN - 1 + int'(code));
    endfunction

    function automatic logic [CNT_W-1:0] pre_load(input logic [1:0] code);
        return CNT_W'(PRE_MIN - 1 + int'(code));
    endfunction

endpackage

// File: rtl/rfsh_count.sv
module rfsh_count #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/rfsh_pending.sv
module rfsh_pending (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic arm,
    input  logic take,
    output logic pend
);
    always_ff @(posedge clk) begin
        if (rst)
            pend <= 1'b0;
        else if (tick && arm)
            pend <= 1'b1;
        else if (take || !arm)
            pend <= 1'b0;
    end

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pend && arm && !take) |=> pend);  // R6
endmodule

// File: rtl/rfsh_fsm.sv
module rfsh_fsm
    import rfsh_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  rfsh_cfg_t cfg,
    input  logic      self_want,
    input  logic      take,
    output logic      idle,
    output logic      ras_low,
    output logic      cas_low
);
    rfsh_state_e      st, st_nx;
    logic             self_run;
    logic             zero, load;
    logic [CNT_W-1:0] load_val;

    rfsh_count #(.W(CNT_W)) i_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .zero     (zero)
    );

    always_comb begin
        st_nx    = st;
        load     = 1'b0;
        load_val = '0;
        unique case (st)
            ST_IDLE: if (take) begin
                st_nx    = ST_DLY;
                load     = 1'b1;
                load_val = dly_load(cfg.dly_sel);
            end
            ST_DLY: if (zero) st_nx = ST_CAS;
            ST_CAS: begin
                if (self_run) begin
                    st_nx = ST_SELF;
                end else begin
                    st_nx    = ST_RAS;
                    load     = 1'b1;
                    load_val = ras_load(cfg.ras_w);
                end
            end
            ST_RAS: if (zero) begin
                st_nx    = ST_PRE;
                load     = 1'b1;
                load_val = pre_load(cfg.pre_n);
            end
            ST_SELF: if (!self_want) begin
                st_nx    = ST_PRE;
                load     = 1'b1;
                load_val = pre_load(cfg.pre_n);
            end
            ST_PRE: if (zero) st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            self_run <= 1'b0;
        end else begin
            st <= st_nx;
            if (st == ST_IDLE && take)
                self_run <= self_want;
        end
    end

    assign idle    = (st == ST_IDLE);
    assign ras_low = (st == ST_RAS) || (st == ST_SELF);
    assign cas_low = (st == ST_CAS) || ras_low;

    AST_CAS_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (st == ST_CAS) |=> (st != ST_CAS));  // R3
    AST_PRE_STAY: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PRE && !zero) |=> (st == ST_PRE));  // R5
    AST_SELF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SELF && self_want) |=> (st == ST_SELF));  // R7
    AST_SELF_EXIT: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SELF && !self_want) |=> (st == ST_PRE));  // R8
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
    import rfsh_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rfsh_en_i,
    input  logic       self_mode_i,
    input  logic       dly_sel_i,
    input  logic [1:0] ras_w_i,
    input  logic [1:0] pre_cnt_i,
    input  logic       tick_i,
    input  logic       gnt_i,
    output logic       req_o,
    output logic       own_o,
    output logic       ras_n_o,
    output logic       cas_n_o
);
    rfsh_cfg_t cfg;
    logic      self_want, cbr_arm, pend, idle, take, ras_low, cas_low;

    assign cfg       = '{dly_sel: dly_sel_i, ras_w: ras_w_i, pre_n: pre_cnt_i};
    assign self_want = rfsh_en_i && self_mode_i;
    assign cbr_arm   = rfsh_en_i && !self_mode_i;
    assign req_o     = idle && (self_want || (cbr_arm && pend));
    assign take      = req_o && gnt_i;

    rfsh_pending i_pend (
        .clk  (clk),
        .rst  (rst),
        .tick (tick_i),
        .arm  (cbr_arm),
        .take (take),
        .pend (pend)
    );

    rfsh_fsm i_fsm (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .self_want (self_want),
        .take      (take),
        .idle      (idle),
        .ras_low   (ras_low),
        .cas_low   (cas_low)
    );

    assign own_o   = !idle;
    assign ras_n_o = !ras_low;
    assign cas_n_o = !cas_low;

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (ras_n_o && cas_n_o && !own_o));  // R1
    AST_RAS_NEEDS_CAS: assert property (@(posedge clk) disable iff (rst)
        !ras_n_o |-> !cas_n_o);  // R4
    AST_OWN_AFTER_GNT: assert property (@(posedge clk) disable iff (rst)
        $rose(own_o) |-> $past(req_o && gnt_i));  // R9
    AST_REQ_WAIT: assert property (@(posedge clk) disable iff (rst)
        (req_o && !gnt_i && cbr_arm) |=> (req_o || !cbr_arm));  // R9
endmodule

// File: tb/test_dram_refresh_ctrl.sv
module test_dram_refresh_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0, selfm = 1'b0, dly = 1'b0, tick = 1'b0, gnt = 1'b0;
    logic [1:0] rw = 2'd0, pc = 2'd0;
    logic       req, own, ras_n, cas_n;
    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    dram_refresh_ctrl i_dram_refresh_ctrl (
        .clk(clk), .rst(rst), .rfsh_en_i(en), .self_mode_i(selfm),
        .dly_sel_i(dly), .ras_w_i(rw), .pre_cnt_i(pc), .tick_i(tick),
        .gnt_i(gnt), .req_o(req), .own_o(own), .ras_n_o(ras_n), .cas_n_o(cas_n)
    );

    task automatic chk(input bit ok, input string r, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic int pins();
        return {29'd0, ras_n, cas_n, own};
    endfunction

    task automatic count_rises(input int n, output int rises);
        bit prev = own;
        rises = 0;
        for (int i = 0; i < n; i++) begin
            step();
            if (own && !prev) rises++;
            prev = own;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int e3, e4, e5, e7, e8, bad, r, D, W, P, exp;
        step(); step(); step();
        // R1 reset state
        chk(ras_n == 1'b1, "R1", "ras_n in reset", ras_n, 1);
        chk(cas_n == 1'b1, "R1", "cas_n in reset", cas_n, 1);
        rst = 1'b0;
        step();
        chk(req == 1'b0, "R1", "req after reset", req, 0);
        chk(own == 1'b0, "R1", "own after reset", own, 0);

        // R2 ticks ignored while disabled
        bad = 0;
        for (int i = 0; i < 12; i++) begin
            tick = (i % 3 == 0);
            gnt  = 1'b1;
            step();
            if (req || own) bad++;
        end
        tick = 1'b0;
        chk(bad == 0, "R2", "activity while disabled", bad, 0);

        // R3 R4 R5 sweep over every CAS-before-RAS configuration
        for (int d = 0; d < 2; d++)
        for (int w = 0; w < 4; w++)
        for (int p = 0; p < 4; p++) begin
            dly = d[0]; rw = w[1:0]; pc = p[1:0];
            D = 1 + d; W = 2 + w; P = 1 + p;
            en = 1'b1; selfm = 1'b0; gnt = 1'b1; tick = 1'b1;
            step();
            tick = 1'b0;
            chk(req == 1'b1, "R2", "req after tick", req, 1);
            step();
            e3 = 0; e4 = 0; e5 = 0;
            for (int i = 0; i <= D + W + P; i++) begin
                if (i < D)           exp = 3'b111;
                else if (i == D)     exp = 3'b101;
                else if (i <= D + W) exp = 3'b001;
                else if (i <= D + W + P - 0 && i < D + 1 + W + P) exp = 3'b111;
                else                 exp = 3'b110;
                if (pins() != exp) begin
                    if (i <= D) e3++;
                    else if (i <= D + W) e4++;
                    else e5++;
                end
                step();
            end
            chk(e3 == 0, "R3", "delay/CAS phase mismatches", e3, 0);
            chk(e4 == 0, "R4", "RAS window mismatches", e4, 0);
            chk(e5 == 0, "R5", "precharge mismatches", e5, 0);
            step();
        end

        // R9 request held without grant
        dly = 1'b0; rw = 2'd1; pc = 2'd1;
        gnt = 1'b0; tick = 1'b1;
        step();
        tick = 1'b0;
        bad = 0;
        for (int i = 0; i < 10; i++) begin
            if (!req || own) bad++;
            step();
        end
        chk(bad == 0, "R9", "req held, own low without grant", bad, 0);
        gnt = 1'b1;
        step();
        chk(own == 1'b1, "R9", "own after grant", own, 1);
        count_rises(30, r);
        chk(r == 0, "R9", "extra refresh after served request", r, 0);

        // R6 ticks during a running refresh collapse into one
        gnt = 1'b1; tick = 1'b1;
        step();
        tick = 1'b0;
        r = 0;
        begin
            bit prev = own;
            for (int i = 0; i < 80; i++) begin
                tick = (i == 3 || i == 5 || i == 7);
                step();
                if (own && !prev) r++;
                prev = own;
            end
        end
        tick = 1'b0;
        chk(r == 2, "R6", "refreshes for ticks during refresh", r, 2);

        // R6 ticks while grant is withheld collapse into one
        gnt = 1'b0;
        for (int i = 0; i < 6; i++) begin
            tick = (i == 1 || i == 4);
            step();
        end
        tick = 1'b0; gnt = 1'b1;
        count_rises(60, r);
        chk(r == 1, "R6", "refreshes for ticks during withheld grant", r, 1);

        // R7 R8 R10 self-refresh sweep
        for (int d = 0; d < 2; d++)
        for (int p = 0; p < 4; p++) begin
            dly = d[0]; pc = p[1:0]; rw = 2'd3;
            D = 1 + d; P = 1 + p;
            en = 1'b1; selfm = 1'b1; gnt = 1'b1;
            step();
            e7 = 0;
            for (int i = 0; i <= D; i++) begin
                exp = (i < D) ? 3'b111 : 3'b101;
                if (pins() != exp) e7++;
                step();
            end
            for (int i = 0; i < 20; i++) begin
                tick = (i % 4 == 1);
                if (pins() != 3'b001) e7++;
                step();
            end
            tick = 1'b0;
            chk(e7 == 0, "R7", "self-refresh strobes", e7, 0);
            if (p[0]) selfm = 1'b0; else en = 1'b0;
            step();
            e8 = 0;
            for (int i = 0; i <= P; i++) begin
                exp = (i < P) ? 3'b111 : 3'b110;
                if (pins() != exp) e8++;
                step();
            end
            chk(e8 == 0, "R8", "self-refresh exit precharge", e8, 0);
            count_rises(30, r);
            chk(r == 0, "R10", "refresh after self-refresh exit", r, 0);
            en = 1'b0; selfm = 1'b0;
            step();
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule